// File: doc/BRIEF.md
# I/O BAR Window Decoder

This block steers an I/O port access to the device window that owns it. A small table describes up to `NUM_DEV` devices. Each device carries an interrupt line number, a count of active base registers and up to six window entries. Each entry holds a base port and a flag saying whether a handler is attached. All windows have one fixed size. An entry takes part in the decode only if its index is below the device's active count and a handler is attached.

Every access is compared against every live window in the same cycle. The result is registered and presented one cycle after the access strobe. It contains a hit flag, the owning device and entry, and the offset of the port inside the window. When no window owns a read, the block supplies all-ones read data. When no window owns a write, the block flags the write as dropped.

While a result is presented, the attached handler may request an interrupt. The block then translates the request into the owning device's assigned interrupt number. Without a request, or on a miss, it shows the no-interrupt code 0xFF. The table is loaded through a plain write port, one entry or one device record per cycle.

Top module: `iobar_window_decoder`

## Requirements
- R1: A window owns the ports from its base up to base + `IO_WIN_SIZE` - 1. Bits [1:0] of a stored base are type bits and are cleared before the comparison, so base 0x1001 covers 0x1000..0x100F when the size is 16.
- R2: An entry whose handler flag is 0 never owns a port, even when the port lies inside its window.
- R3: Only entries with index below the device's active count take part. A count written above 6 is held as 6. Entry writes to index 6 or 7 are ignored.
- R4: When several live windows contain the port, the selected one is the last in scan order. The scan runs over devices in ascending order, and over entries in ascending order within each device.
- R5: On a hit, `res_offset` equals the port minus the stored base with bits [1:0] cleared.
- R6: On a read that no window owns, `res_miss_rdata` is 0xFFFFFFFF. In every other case it is 0.
- R7: On a write that no window owns, `res_drop` is 1. On a write that a window owns, and on any read, `res_drop` is 0.
- R8: `irq_out` shows the interrupt number of the owning device when `res_valid`, `res_hit` and `hnd_irq_req` are all high. In all other cases it shows 0xFF. The number is the one the device held when the access was decoded.
- R9: `res_valid` is high in exactly the cycle after each `acc_valid` cycle, and low at all other times.
- R10: A table write in the same cycle as an access takes effect for later accesses only. The access is decoded against the earlier table contents.
- R11: After reset, every device has count 0 and every handler flag is 0. Accesses therefore miss, `res_valid` is 0 and `irq_out` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_port | input | ADDR_W (16) | Accessed I/O port |
| ent_we | input | 1 | Write one window entry |
| dev_we | input | 1 | Write one device record (count and interrupt number) |
| wr_dev | input | DEV_W (5) | Device index for table writes |
| wr_bar | input | 3 | Entry index for entry writes |
| wr_base | input | ADDR_W (16) | Base port for entry writes, bits [1:0] are type bits |
| wr_handler | input | 1 | Handler-attached flag for entry writes |
| wr_bar_cnt | input | 3 | Active entry count for device writes |
| wr_irq | input | 8 | Interrupt number for device writes |
| hnd_irq_req | input | 1 | Handler interrupt request for the presented result |
| res_valid | output | 1 | Result valid |
| res_write | output | 1 | Direction of the decoded access |
| res_hit | output | 1 | A live window owns the port |
| res_dev | output | DEV_W (5) | Owning device |
| res_bar | output | 3 | Owning entry |
| res_offset | output | ADDR_W (16) | Port offset within the window |
| res_miss_rdata | output | 32 | Default read data for an unowned read |
| res_drop | output | 1 | Unowned write discarded |
| irq_out | output | 8 | Mapped interrupt number, 0xFF for none |

## Verification
Two functions can fall in the same cycle. A table update can arrive in the cycle an access is decoded. An interrupt request for the previous result can also be presented while the table changes.

The bench provokes the first case on purpose. It raises a device's active count in the very cycle of an access that only the new count would let hit. The first access must miss, and an identical access right after must hit. This checks that the decode sees the earlier contents and the write lands for the next access.

The interrupt number is judged against the bench's table model as it stood when the access was issued. This checks that R8 holds even when the device record changes before the request is presented.

// File: rtl/iobar_pkg.sv
package iobar_pkg;

  // Low bits of a stored base that carry the I/O type marker.
  localparam logic [31:0] IO_TYPE_BITS = 32'h0000_0003;

  // Stored base with the type bits cleared.
  function automatic logic [31:0] io_clean_base(input logic [31:0] base);
    return base & ~IO_TYPE_BITS;
  endfunction

  // True when port lies in [clean base, clean base + size).
  function automatic logic io_in_window(input logic [31:0] port,
                                        input logic [31:0] base,
                                        input logic [31:0] size);
    logic [32:0] lo;
    logic [32:0] hi;
    lo = {1'b0, io_clean_base(base)};
    hi = lo + {1'b0, size};
    return ({1'b0, port} >= lo) && ({1'b0, port} < hi);
  endfunction

  // Offset of port from the clean base.
  function automatic logic [31:0] io_offset(input logic [31:0] port,
                                            input logic [31:0] base);
    return port - io_clean_base(base);
  endfunction

  // Count limited to the per-device maximum.
  function automatic logic [7:0] io_clamp_count(input logic [7:0] cnt,
                                                input logic [7:0] max_cnt);
    return (cnt > max_cnt) ? max_cnt : cnt;
  endfunction

endpackage

// File: rtl/iobar_table.sv
module iobar_table #(
  parameter int NUM_DEV = 32,
  parameter int MAX_BAR = 6,
  parameter int ADDR_W  = 16,
  parameter int IRQ_W   = 8,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int BAR_W   = 3,
  parameter int CNT_W   = 3,
  parameter int NUM_ENT = NUM_DEV * MAX_BAR
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ent_we,
  input  logic                            dev_we,
  input  logic [DEV_W-1:0]                wr_dev,
  input  logic [BAR_W-1:0]                wr_bar,
  input  logic [ADDR_W-1:0]               wr_base,
  input  logic                            wr_handler,
  input  logic [CNT_W-1:0]                wr_bar_cnt,
  input  logic [IRQ_W-1:0]                wr_irq,
  output logic [NUM_ENT-1:0][ADDR_W-1:0]  ent_base,
  output logic [NUM_ENT-1:0]              ent_live,
  output logic [NUM_DEV-1:0][IRQ_W-1:0]   dev_irq
);
  import iobar_pkg::*;

  logic [CNT_W-1:0] clamped_cnt;
  assign clamped_cnt = CNT_W'(io_clamp_count(8'(wr_bar_cnt), 8'(MAX_BAR)));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [CNT_W-1:0] cnt_q;
    logic [IRQ_W-1:0] irq_q;
    logic             dev_sel;

    assign dev_sel = (wr_dev == DEV_W'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        irq_q <= '0;
      end else if (dev_we && dev_sel) begin
        cnt_q <= clamped_cnt;
        irq_q <= wr_irq;
      end
    end

    assign dev_irq[d] = irq_q;

    for (genvar b = 0; b < MAX_BAR; b++) begin : g_bar
      logic [ADDR_W-1:0] base_q;
      logic              hnd_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q <= '0;
          hnd_q  <= 1'b0;
        end else if (ent_we && dev_sel && (wr_bar == BAR_W'(b))) begin
          base_q <= wr_base;
          hnd_q  <= wr_handler;
        end
      end

      assign ent_base[d*MAX_BAR + b] = base_q;
      assign ent_live[d*MAX_BAR + b] = hnd_q && (CNT_W'(b) < cnt_q);
    end
  end

endmodule

// File: rtl/iobar_scan.sv
module iobar_scan #(
  parameter int NUM_DEV     = 32,
  parameter int MAX_BAR     = 6,
  parameter int ADDR_W      = 16,
  parameter int IO_WIN_SIZE = 16,
  parameter int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int BAR_W       = 3,
  parameter int NUM_ENT     = NUM_DEV * MAX_BAR
) (
  input  logic [ADDR_W-1:0]               port,
  input  logic [NUM_ENT-1:0][ADDR_W-1:0]  ent_base,
  input  logic [NUM_ENT-1:0]              ent_live,
  output logic                            hit,
  output logic [DEV_W-1:0]                dev,
  output logic [BAR_W-1:0]                bar,
  output logic [ADDR_W-1:0]               offset
);
  import iobar_pkg::*;

  // Per-entry match vector; a later match overrides an earlier one.
  logic [NUM_ENT-1:0] match;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    assign match[e] = ent_live[e] &&
                      io_in_window(32'(port), 32'(ent_base[e]), 32'(IO_WIN_SIZE));
  end

  always_comb begin
    hit    = 1'b0;
    dev    = '0;
    bar    = '0;
    offset = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int b = 0; b < MAX_BAR; b++) begin
        if (match[d*MAX_BAR + b]) begin
          hit    = 1'b1;
          dev    = DEV_W'(d);
          bar    = BAR_W'(b);
          offset = ADDR_W'(io_offset(32'(port), 32'(ent_base[d*MAX_BAR + b])));
        end
      end
    end
  end

endmodule

// File: rtl/iobar_result_reg.sv
module iobar_result_reg #(
  parameter int ADDR_W = 16,
  parameter int IRQ_W  = 8,
  parameter int DEV_W  = 5,
  parameter int BAR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic              in_hit,
  input  logic [DEV_W-1:0]  in_dev,
  input  logic [BAR_W-1:0]  in_bar,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [IRQ_W-1:0]  in_irq,
  output logic              out_valid,
  output logic              out_write,
  output logic              out_hit,
  output logic [DEV_W-1:0]  out_dev,
  output logic [BAR_W-1:0]  out_bar,
  output logic [ADDR_W-1:0] out_offset,
  output logic [IRQ_W-1:0]  out_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_write  <= 1'b0;
      out_hit    <= 1'b0;
      out_dev    <= '0;
      out_bar    <= '0;
      out_offset <= '0;
      out_irq    <= '1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_write  <= in_write;
        out_hit    <= in_hit;
        out_dev    <= in_dev;
        out_bar    <= in_bar;
        out_offset <= in_offset;
        out_irq    <= in_irq;
      end
    end
  end

endmodule

// File: rtl/iobar_window_decoder.sv
module iobar_window_decoder #(
  parameter int NUM_DEV     = 32,
  parameter int MAX_BAR     = 6,
  parameter int ADDR_W      = 16,
  parameter int IO_WIN_SIZE = 16,
  parameter int IRQ_W       = 8,
  parameter int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int BAR_W       = 3,
  parameter int CNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_port,
  input  logic              ent_we,
  input  logic              dev_we,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [BAR_W-1:0]  wr_bar,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              wr_handler,
  input  logic [CNT_W-1:0]  wr_bar_cnt,
  input  logic [IRQ_W-1:0]  wr_irq,
  input  logic              hnd_irq_req,
  output logic              res_valid,
  output logic              res_write,
  output logic              res_hit,
  output logic [DEV_W-1:0]  res_dev,
  output logic [BAR_W-1:0]  res_bar,
  output logic [ADDR_W-1:0] res_offset,
  output logic [31:0]       res_miss_rdata,
  output logic              res_drop,
  output logic [IRQ_W-1:0]  irq_out
);
  localparam int NUM_ENT = NUM_DEV * MAX_BAR;
  localparam logic [IRQ_W-1:0] NO_IRQ = '1;

  // Named internal events
  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_base;
  logic [NUM_ENT-1:0]             ent_live;
  logic [NUM_DEV-1:0][IRQ_W-1:0]  dev_irq;
  logic                           scan_hit;
  logic [DEV_W-1:0]               scan_dev;
  logic [BAR_W-1:0]               scan_bar;
  logic [ADDR_W-1:0]              scan_off;
  logic [IRQ_W-1:0]               scan_irq;
  logic [IRQ_W-1:0]               held_irq;
  logic                           irq_fire;

  iobar_table #(
    .NUM_DEV(NUM_DEV), .MAX_BAR(MAX_BAR), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W),
    .DEV_W(DEV_W), .BAR_W(BAR_W), .CNT_W(CNT_W), .NUM_ENT(NUM_ENT)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_we     (ent_we),
    .dev_we     (dev_we),
    .wr_dev     (wr_dev),
    .wr_bar     (wr_bar),
    .wr_base    (wr_base),
    .wr_handler (wr_handler),
    .wr_bar_cnt (wr_bar_cnt),
    .wr_irq     (wr_irq),
    .ent_base   (ent_base),
    .ent_live   (ent_live),
    .dev_irq    (dev_irq)
  );

  iobar_scan #(
    .NUM_DEV(NUM_DEV), .MAX_BAR(MAX_BAR), .ADDR_W(ADDR_W),
    .IO_WIN_SIZE(IO_WIN_SIZE), .DEV_W(DEV_W), .BAR_W(BAR_W), .NUM_ENT(NUM_ENT)
  ) u_scan (
    .port     (acc_port),
    .ent_base (ent_base),
    .ent_live (ent_live),
    .hit      (scan_hit),
    .dev      (scan_dev),
    .bar      (scan_bar),
    .offset   (scan_off)
  );

  assign scan_irq = dev_irq[scan_dev];

  iobar_result_reg #(
    .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .DEV_W(DEV_W), .BAR_W(BAR_W)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (acc_valid),
    .in_write   (acc_write),
    .in_hit     (scan_hit),
    .in_dev     (scan_dev),
    .in_bar     (scan_bar),
    .in_offset  (scan_off),
    .in_irq     (scan_irq),
    .out_valid  (res_valid),
    .out_write  (res_write),
    .out_hit    (res_hit),
    .out_dev    (res_dev),
    .out_bar    (res_bar),
    .out_offset (res_offset),
    .out_irq    (held_irq)
  );

  assign res_miss_rdata = (res_valid && !res_hit && !res_write) ? 32'hFFFF_FFFF : 32'h0;
  assign res_drop       = res_valid && !res_hit && res_write;
  assign irq_fire       = res_valid && res_hit && hnd_irq_req;
  assign irq_out        = irq_fire ? held_irq : NO_IRQ;

endmodule

// File: rtl/iobar_decoder_chk.sv
module iobar_decoder_chk #(
  parameter int ADDR_W      = 16,
  parameter int IO_WIN_SIZE = 16,
  parameter int MAX_BAR     = 6,
  parameter int IRQ_W       = 8,
  parameter int DEV_W       = 5,
  parameter int BAR_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              hnd_irq_req,
  input logic              scan_hit,
  input logic [ADDR_W-1:0] scan_off,
  input logic              res_valid,
  input logic              res_write,
  input logic              res_hit,
  input logic [BAR_W-1:0]  res_bar,
  input logic [ADDR_W-1:0] res_offset,
  input logic [31:0]       res_miss_rdata,
  input logic              res_drop,
  input logic [IRQ_W-1:0]  irq_out
);

  p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  p_scan_carried_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && scan_hit) |=> (res_hit && res_offset == $past(scan_off)));

  p_offset_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (32'(res_offset) < 32'(IO_WIN_SIZE)));

  p_bar_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (32'(res_bar) < 32'(MAX_BAR)));

  p_miss_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !res_write) |-> (res_miss_rdata == 32'hFFFF_FFFF));

  p_drop_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop |-> (res_valid && res_write && !res_hit && res_miss_rdata == 32'h0));

  p_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_hit && hnd_irq_req) |-> (irq_out == '1));

endmodule

bind iobar_window_decoder iobar_decoder_chk #(
  .ADDR_W(ADDR_W), .IO_WIN_SIZE(IO_WIN_SIZE), .MAX_BAR(MAX_BAR),
  .IRQ_W(IRQ_W), .DEV_W(DEV_W), .BAR_W(BAR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .hnd_irq_req    (hnd_irq_req),
  .scan_hit       (scan_hit),
  .scan_off       (scan_off),
  .res_valid      (res_valid),
  .res_write      (res_write),
  .res_hit        (res_hit),
  .res_bar        (res_bar),
  .res_offset     (res_offset),
  .res_miss_rdata (res_miss_rdata),
  .res_drop       (res_drop),
  .irq_out        (irq_out)
);

// File: tb/tb_iobar_window_decoder.sv
module tb_iobar_window_decoder;

  localparam int NUM_DEV = 32;
  localparam int MAX_BAR = 6;
  localparam int WIN     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_port = '0;
  logic        ent_we = 1'b0;
  logic        dev_we = 1'b0;
  logic [4:0]  wr_dev = '0;
  logic [2:0]  wr_bar = '0;
  logic [15:0] wr_base = '0;
  logic        wr_handler = 1'b0;
  logic [2:0]  wr_bar_cnt = '0;
  logic [7:0]  wr_irq = '0;
  logic        hnd_irq_req = 1'b0;
  logic        res_valid, res_write, res_hit, res_drop;
  logic [4:0]  res_dev;
  logic [2:0]  res_bar;
  logic [15:0] res_offset;
  logic [31:0] res_miss_rdata;
  logic [7:0]  irq_out;

  iobar_window_decoder dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench table model
  int m_cnt [NUM_DEV];
  int m_irq [NUM_DEV];
  int m_base[NUM_DEV][MAX_BAR];
  bit m_hnd [NUM_DEV][MAX_BAR];

  typedef struct {
    int    due;
    bit    write;
    bit    hit;
    int    dev;
    int    bar;
    int    off;
    int    rdata;
    bit    drop;
    int    irq;
    string tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  // Expected result: search from the end of scan order backwards, first match wins.
  function automatic exp_t predict(input int port, input bit wr, input bit irq_req, input string tag);
    exp_t e;
    e.write = wr; e.hit = 1'b0; e.dev = 0; e.bar = 0; e.off = 0; e.tag = tag;
    for (int d = NUM_DEV - 1; d >= 0 && !e.hit; d--) begin
      for (int b = MAX_BAR - 1; b >= 0 && !e.hit; b--) begin
        int lo;
        lo = m_base[d][b] - (m_base[d][b] % 4);
        if (b < m_cnt[d] && m_hnd[d][b] && port >= lo && port < lo + WIN) begin
          e.hit = 1'b1; e.dev = d; e.bar = b; e.off = port - lo;
        end
      end
    end
    e.rdata = (!e.hit && !wr) ? 32'hFFFF_FFFF : 0;
    e.drop  = !e.hit && wr;
    e.irq   = (e.hit && irq_req) ? m_irq[e.dev] : 8'hFF;
    return e;
  endfunction

  task automatic wr_entry(input int d, input int b, input int base, input bit hnd);
    @(posedge clk); #1;
    ent_we = 1'b1; wr_dev = 5'(d); wr_bar = 3'(b); wr_base = 16'(base); wr_handler = hnd;
    @(posedge clk); #1;
    ent_we = 1'b0;
    if (b < MAX_BAR) begin m_base[d][b] = base; m_hnd[d][b] = hnd; end
  endtask

  task automatic wr_device(input int d, input int cnt, input int irq);
    @(posedge clk); #1;
    dev_we = 1'b1; wr_dev = 5'(d); wr_bar_cnt = 3'(cnt); wr_irq = 8'(irq);
    @(posedge clk); #1;
    dev_we = 1'b0;
    m_cnt[d] = (cnt > MAX_BAR) ? MAX_BAR : cnt; m_irq[d] = irq;
  endtask

  // Access with an optional device write in the same cycle.
  task automatic access_x(input int port, input bit wr, input bit irq_req, input string tag,
                          input bit also_dev, input int d, input int cnt, input int irq);
    exp_t e;
    @(posedge clk); #1;
    e = predict(port, wr, irq_req, tag);
    e.due = cyc + 1;
    sb.push_back(e);
    acc_valid = 1'b1; acc_write = wr; acc_port = 16'(port);
    if (also_dev) begin
      dev_we = 1'b1; wr_dev = 5'(d); wr_bar_cnt = 3'(cnt); wr_irq = 8'(irq);
    end
    @(posedge clk); #1;
    acc_valid = 1'b0; dev_we = 1'b0; hnd_irq_req = irq_req;
    if (also_dev) begin
      m_cnt[d] = (cnt > MAX_BAR) ? MAX_BAR : cnt; m_irq[d] = irq;
    end
    @(posedge clk); #1;
    hnd_irq_req = 1'b0;
  endtask

  task automatic access(input int port, input bit wr, input bit irq_req, input string tag);
    access_x(port, wr, irq_req, tag, 1'b0, 0, 0, 0);
  endtask

  // Monitor: compares results away from the active edge.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected res_valid", "no result");
      end else begin
        exp_t e;
        bit ok;
        e = sb.pop_front();
        ok = (cyc == e.due) && (res_write == e.write) && (res_hit == e.hit) &&
             (res_miss_rdata == 32'(e.rdata)) && (res_drop == e.drop) &&
             (irq_out == 8'(e.irq)) &&
             (!e.hit || (res_dev == 5'(e.dev) && res_bar == 3'(e.bar) && res_offset == 16'(e.off)));
        check(ok, e.tag,
          $sformatf("cyc=%0d hit=%0b dev=%0d bar=%0d off=%0d rd=%h drop=%0b irq=%0d",
                    cyc, res_hit, res_dev, res_bar, res_offset, res_miss_rdata, res_drop, irq_out),
          $sformatf("cyc=%0d hit=%0b dev=%0d bar=%0d off=%0d rd=%h drop=%0b irq=%0d",
                    e.due, e.hit, e.dev, e.bar, e.off, e.rdata, e.drop, e.irq));
      end
    end
  end

  initial begin
    for (int d = 0; d < NUM_DEV; d++) begin
      m_cnt[d] = 0; m_irq[d] = 0;
      for (int b = 0; b < MAX_BAR; b++) begin m_base[d][b] = 0; m_hnd[d][b] = 1'b0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res_valid == 1'b0, "R11", $sformatf("res_valid=%0b", res_valid), "0");
    check(irq_out == 8'hFF, "R11", $sformatf("irq=%h", irq_out), "ff");
    rst_n = 1'b1;

    access(16'h0000, 1'b0, 1'b1, "R11 empty table miss");

    // Table setup
    wr_device(0, 2, 3);
    wr_entry(0, 0, 16'h1001, 1'b1);
    wr_entry(0, 1, 16'h1010, 1'b0);
    wr_device(1, 1, 5);
    wr_entry(1, 0, 16'h1008, 1'b1);
    wr_device(31, 6, 15);
    wr_entry(31, 4, 16'h2000, 1'b1);
    wr_entry(31, 5, 16'h2003, 1'b1);
    wr_device(2, 1, 9);
    wr_entry(2, 1, 16'h3000, 1'b1);
    wr_device(3, 7, 11);
    wr_entry(3, 5, 16'h4000, 1'b1);
    wr_entry(4, 6, 16'h5000, 1'b1);   // ignored: index 6
    wr_device(4, 6, 12);

    access(16'h1000, 1'b0, 1'b0, "R1 R5 window start");
    access(16'h1007, 1'b0, 1'b0, "R5 offset 7");
    access(16'h0FFF, 1'b0, 1'b0, "R1 R6 below base");
    access(16'h100F, 1'b0, 1'b0, "R4 later device wins");
    access(16'h1018, 1'b0, 1'b0, "R2 no handler");
    access(16'h1020, 1'b0, 1'b0, "R1 past window end");
    access(16'h2005, 1'b0, 1'b0, "R4 later entry wins");
    access(16'h3000, 1'b0, 1'b0, "R3 entry above count");
    access(16'h4003, 1'b0, 1'b0, "R3 clamped count");
    access(16'h5000, 1'b0, 1'b0, "R3 entry index 6 ignored");
    access(16'h6000, 1'b1, 1'b0, "R7 write miss dropped");
    access(16'h1001, 1'b1, 1'b0, "R7 write hit kept");
    access(16'h1002, 1'b0, 1'b1, "R8 irq dev0");
    access(16'h2000, 1'b1, 1'b1, "R8 irq dev31");
    access(16'h7000, 1'b0, 1'b1, "R8 miss no irq");
    access(16'h1003, 1'b0, 1'b0, "R8 hit no request");

    // Same-cycle table write: decoded against old contents, then new.
    access_x(16'h3004, 1'b0, 1'b1, "R10 old contents", 1'b1, 2, 2, 6);
    access(16'h3004, 1'b0, 1'b1, "R10 new contents");
    // Device interrupt number changed in the decode cycle: old one held.
    access_x(16'h1004, 1'b0, 1'b1, "R8 R10 irq captured at decode", 1'b1, 0, 2, 7);
    access(16'h1004, 1'b0, 1'b1, "R8 new irq");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R9", $sformatf("pending=%0d", sb.size()), "0");
    check(res_valid == 1'b0, "R9", $sformatf("res_valid=%0b", res_valid), "0");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule